// File: doc/BRIEF.md
# Minimal Load-Store Processor Core

This block is a small multicycle processor. It keeps instructions and data in one shared word memory. It holds sixteen 32-bit registers, and register 15 is also the program counter. The core fetches the word that the program counter addresses, advances the counter by one word, and then executes that word. Whatever word it fetches is treated as an instruction, including words that were written as data.

Only loads and stores touch memory. Arithmetic, move and compare work on registers only. A compare records signed flags, and a later branch tests them. A supervisor call with number 2 stops the core for good. An unknown opcode also stops the core, which exposes runaway execution.

The core connects to a single-port synchronous memory. The memory returns read data one cycle after the address is presented. Each instruction takes three cycles: fetch address, capture, execute. A load takes one extra cycle to capture its data. A store drives its write during the execute cycle.

Top module: `lsp_core`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `mem_addr` is 0, `mem_we` is 0 and `halted` is 0. Every register, including the program counter (register 15), is cleared to 0.
- R2: Instruction words are 32 bits: opcode [31:28], condition [27:24], Rd [23:20], Rn [19:16], Rm [15:12], and a signed word offset [11:0]. Each instruction uses three cycles (fetch address, capture, execute), and each fetch adds 4 to register 15.
- R3: Load (opcode 0) writes Rd with the memory word at address A + 8 + 4*offset, where A is the instruction's own address. The data is captured one cycle after the execute cycle.
- R4: Store (opcode 1) writes Rd to the word at A + 8 + 4*offset. The write-enable is high for exactly one cycle, and no other memory word changes.
- R5: ADD (2), SUB (3) and MUL (4) write Rd with Rn+Rm, Rn-Rm and the low 32 bits of Rn*Rm. MOV (5) writes Rd with Rm.
- R6: A supervisor call (opcode 8) whose offset field is 2 halts the core. `halted` rises one cycle after that call's execute cycle and stays high. After that no fetch and no write occurs. A supervisor call with any other number does nothing.
- R7: Compare (opcode 6) computes Rn-Rm and records negative, zero and signed overflow. It writes no register, even when its Rd field is nonzero.
- R8: Branch (opcode 7) loads register 15 with A + 8 + 4*offset when its condition holds. Condition codes: 0 always, 1 equal, 2 not equal, 3 signed ≥, 4 signed <, 5 signed >, 6 signed ≤, and any other code never. A branch that is not taken continues at A+4.
- R9: An opcode from 9 to 15 halts the core in the same way as R6. A word placed in memory as data is executed like any other instruction when the program counter reaches it.
- R10: Register 15 used as a source gives A+4. Writing register 15 with MOV, ADD, SUB, MUL or load makes the next fetch come from the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 32 | Byte address to memory (word aligned) |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 32 | Read data, valid the cycle after the address |
| halted | output | 1 | High once the core has stopped |

## Verification
The hardest cases to reach from the ports are the condition outcomes that depend on signed overflow in the compare, for example the most negative word against a positive one. Equally hard is control flow that passes through register 15 as an ordinary operand. The bench reaches them by loading a short program and its data words into the memory model while reset is held. Each branch condition is run against operand pairs that include equal values, sign mixes and the overflow pair. Each taken or not-taken outcome, and each register value, is written to a memory word that the bench then reads back.

// File: rtl/lsp_core.sv
module lsp_core (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic        mem_we,
  input  logic [31:0] mem_rdata,
  output logic        halted
);
  localparam logic [3:0] OP_LDR = 4'd0, OP_STR = 4'd1, OP_ADD = 4'd2, OP_SUB = 4'd3,
                         OP_MUL = 4'd4, OP_MOV = 4'd5, OP_CMP = 4'd6, OP_BR  = 4'd7,
                         OP_SVC = 4'd8;

  typedef enum logic [2:0] {S_FETCH, S_CAPT, S_EXEC, S_LOAD, S_HALT} state_t;

  state_t      st;
  logic [31:0] rf [16];
  logic [31:0] ir;
  logic        fn, fz, fv;
  logic        take;

  wire [3:0]  op  = ir[31:28];
  wire [3:0]  cnd = ir[27:24];
  wire [3:0]  rd  = ir[23:20];
  wire [3:0]  rn  = ir[19:16];
  wire [3:0]  rm  = ir[15:12];
  wire [31:0] pc  = rf[15];
  wire [31:0] va  = rf[rn];
  wire [31:0] vb  = rf[rm];
  wire [31:0] ea  = pc + 32'd4 + {{18{ir[11]}}, ir[11:0], 2'b00};
  wire [31:0] dif = va - vb;
  wire [31:0] prd = va * vb;
  wire        ovf = (va[31] != vb[31]) && (dif[31] != va[31]);
  wire        mem_op = (st == S_EXEC) && (op == OP_LDR || op == OP_STR);

  assign mem_addr  = mem_op ? ea : pc;
  assign mem_we    = (st == S_EXEC) && (op == OP_STR);
  assign mem_wdata = rf[rd];
  assign halted    = (st == S_HALT);

  always_comb begin
    case (cnd)
      4'd0:    take = 1'b1;
      4'd1:    take = fz;
      4'd2:    take = !fz;
      4'd3:    take = (fn == fv);
      4'd4:    take = (fn != fv);
      4'd5:    take = !fz && (fn == fv);
      4'd6:    take = fz || (fn != fv);
      default: take = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_FETCH;
      ir <= '0;
      fn <= 1'b0;
      fz <= 1'b0;
      fv <= 1'b0;
      for (int i = 0; i < 16; i++) rf[i] <= '0;
    end else begin
      case (st)
        S_FETCH: st <= S_CAPT;
        S_CAPT: begin
          ir     <= mem_rdata;
          rf[15] <= pc + 32'd4;
          st     <= S_EXEC;
        end
        S_EXEC: begin
          st <= S_FETCH;
          case (op)
            OP_LDR: st <= S_LOAD;
            OP_STR: ;
            OP_ADD: rf[rd] <= va + vb;
            OP_SUB: rf[rd] <= dif;
            OP_MUL: rf[rd] <= prd;
            OP_MOV: rf[rd] <= vb;
            OP_CMP: begin
              fn <= dif[31];
              fz <= (dif == 32'd0);
              fv <= ovf;
            end
            OP_BR:  if (take) rf[15] <= ea;
            OP_SVC: if (ir[11:0] == 12'd2) st <= S_HALT;
            default: st <= S_HALT;
          endcase
        end
        S_LOAD: begin
          rf[rd] <= mem_rdata;
          st     <= S_FETCH;
        end
        default: st <= S_HALT;
      endcase
    end
  end
endmodule

module lsp_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] mem_addr,
  input logic        mem_we,
  input logic        halted,
  input logic [2:0]  st,
  input logic [31:0] pc
);
  localparam logic [2:0] CAPT = 3'd1;

  AST_RESET_FETCH_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mem_addr == 32'd0 && !mem_we && !halted)); // R1
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (st == CAPT) |=> (pc == $past(pc) + 32'd4)); // R2
  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we); // R4
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(mem_addr))); // R6
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_we); // R6
endmodule

bind lsp_core lsp_core_chk u_chk (
  .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we),
  .halted(halted), .st(st), .pc(pc)
);

// File: tb/lsp_core_test.sv
module lsp_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we, halted;

  logic [31:0] mem [0:255];
  logic        ld_en = 1'b0, clr = 1'b0;
  logic [7:0]  ld_a = '0;
  logic [31:0] ld_d = '0;
  int          total = 0, bad = 0, cyc = 0;

  always #5 clk = ~clk;

  lsp_core uut (.clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
                .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted));

  always @(posedge clk) begin
    if (clr) for (int i = 0; i < 256; i++) mem[i] <= '0;
    else if (ld_en) mem[ld_a] <= ld_d;
    else if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[9:2]];
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      bad = bad + 1;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("  test done: total=%0d bad=%0d", total + 1, bad);
      $finish;
    end
  end

  function automatic logic [31:0] ins(int op, int cn, int rd, int rn, int rm, int off);
    return {op[3:0], cn[3:0], rd[3:0], rn[3:0], rm[3:0], off[11:0]};
  endfunction
  function automatic int rel(int a, int t);
    return (t - a - 8) / 4;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic begin_prog();
    @(negedge clk); rst = 1'b1; clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic put(int a, logic [31:0] d);
    ld_en = 1'b1; ld_a = a[9:2]; ld_d = d;
    @(negedge clk); ld_en = 1'b0;
  endtask

  task automatic run(string tag);
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 600 && !halted; i++) @(negedge clk);
    chk(halted, tag, {31'd0, halted}, 32'd1);
  endtask

  task automatic t_reset_and_seq();
    int k;
    logic [31:0] held;
    begin_prog();
    put(0, ins(5,0,0,0,0,0)); put(4, ins(5,0,1,0,1,0));
    put(8, ins(5,0,2,0,2,0)); put(12, ins(8,0,0,0,0,2));
    #1;
    chk(mem_addr == 0 && !mem_we && !halted, "R1 in reset", mem_addr, 0);
    @(negedge clk); rst = 1'b0; #1;
    k = 0;
    chk(mem_addr == 0 && !mem_we, "R1 first fetch", mem_addr, 0);
    while (k < 20) begin
      @(negedge clk); k++; #1;
      if (k == 3 || k == 6 || k == 9)
        chk(mem_addr == 32'(k * 4 / 3), "R2 fetch step", mem_addr, 32'(k * 4 / 3));
      if (k == 11) chk(!halted, "R6 not yet halted", {31'd0, halted}, 0);
      if (k == 12) begin
        chk(halted, "R6 halt timing", {31'd0, halted}, 1);
        held = mem_addr;
      end
    end
    chk(halted && mem_addr == held && !mem_we, "R6 stays stopped", mem_addr, held);
  endtask

  task automatic t_arith(logic [31:0] a, logic [31:0] b);
    begin_prog();
    put(0,  ins(0,0,1,0,0,rel(0,64)));
    put(4,  ins(0,0,2,0,0,rel(4,68)));
    put(8,  ins(2,0,3,1,2,0));
    put(12, ins(3,0,4,2,1,0));
    put(16, ins(4,0,5,1,2,0));
    put(20, ins(5,0,6,0,5,0));
    put(24, ins(1,0,3,0,0,rel(24,80)));
    put(28, ins(1,0,4,0,0,rel(28,84)));
    put(32, ins(1,0,5,0,0,rel(32,88)));
    put(36, ins(1,0,6,0,0,rel(36,92)));
    put(40, ins(8,0,0,0,0,2));
    put(64, a); put(68, b); put(96, 32'hA5A5_5A5A);
    run("R6 arith halt");
    chk(mem[20] == a + b, "R5 add (R3 load)", mem[20], a + b);
    chk(mem[21] == b - a, "R5 sub", mem[21], b - a);
    chk(mem[22] == a * b, "R5 mul", mem[22], a * b);
    chk(mem[23] == a * b, "R5 mov (R4 store)", mem[23], a * b);
    chk(mem[24] == 32'hA5A5_5A5A, "R4 neighbour kept", mem[24], 32'hA5A5_5A5A);
  endtask

  task automatic t_branch(int cn, logic [31:0] x, logic [31:0] y);
    bit tk;
    logic [31:0] e;
    case (cn)
      0: tk = 1;
      1: tk = (x == y);
      2: tk = (x != y);
      3: tk = ($signed(x) >= $signed(y));
      4: tk = ($signed(x) <  $signed(y));
      5: tk = ($signed(x) >  $signed(y));
      6: tk = ($signed(x) <= $signed(y));
      default: tk = 0;
    endcase
    e = tk ? 32'd2 : 32'd1;
    begin_prog();
    put(0,  ins(0,0,1,0,0,rel(0,64)));
    put(4,  ins(0,0,2,0,0,rel(4,68)));
    put(8,  ins(6,0,1,1,2,0));
    put(12, ins(7,cn,0,0,0,rel(12,24)));
    put(16, ins(0,0,3,0,0,rel(16,72)));
    put(20, ins(7,0,0,0,0,rel(20,28)));
    put(24, ins(0,0,3,0,0,rel(24,76)));
    put(28, ins(1,0,3,0,0,rel(28,80)));
    put(32, ins(1,0,1,0,0,rel(32,84)));
    put(36, ins(8,0,0,0,0,2));
    put(64, x); put(68, y); put(72, 32'd1); put(76, 32'd2);
    run("R6 branch halt");
    chk(mem[20] == e, $sformatf("R8 cond %0d", cn), mem[20], e);
    chk(mem[21] == x, "R7 compare writes nothing", mem[21], x);
  endtask

  task automatic t_pc_reg();
    begin_prog();
    put(0,  ins(5,0,7,0,15,0));
    put(4,  ins(8,0,0,0,0,5));
    put(8,  ins(0,0,8,0,0,rel(8,64)));
    put(12, ins(5,0,15,0,8,0));
    put(16, ins(8,0,0,0,0,2));
    put(20, ins(8,0,0,0,0,2));
    put(24, ins(1,0,7,0,0,rel(24,80)));
    put(28, ins(8,0,0,0,0,2));
    put(64, 32'd24); put(80, 32'hFFFF_FFFF);
    run("R10 run");
    chk(mem[20] == 32'd4, "R10 pc read and jump (R6 svc 5 no-op)", mem[20], 32'd4);
  endtask

  task automatic t_unknown();
    begin_prog();
    put(0,  ins(0,0,1,0,0,rel(0,64)));
    put(4,  ins(7,0,0,0,0,rel(4,8)));
    put(8,  32'h2021_1000);
    put(12, ins(1,0,2,0,0,rel(12,80)));
    put(16, 32'hB000_0000);
    put(20, ins(1,0,1,0,0,rel(20,84)));
    put(24, ins(8,0,0,0,0,2));
    put(64, 32'd7); put(84, 32'hDEAD_BEEF);
    run("R9 halted");
    chk(mem[20] == 32'd14, "R9 data word executed", mem[20], 32'd14);
    chk(mem[21] == 32'hDEAD_BEEF, "R9 unknown opcode stops", mem[21], 32'hDEAD_BEEF);
  endtask

  initial begin
    t_reset_and_seq();
    t_arith(32'd23, 32'd45);
    t_arith(32'h0001_0001, 32'hFFFF_FFF9);
    for (int cn = 0; cn < 8; cn++) begin
      t_branch(cn, 32'd5, 32'd5);
      t_branch(cn, 32'd3, 32'd9);
      t_branch(cn, 32'd9, 32'd3);
      t_branch(cn, 32'hFFFF_FFFF, 32'd1);
      t_branch(cn, 32'h8000_0000, 32'd1);
      t_branch(cn, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    end
    t_pc_reg();
    t_unknown();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule